// File: doc/BRIEF.md
# Dual-Mode FIFO Read-Port Controller

This block is the read side of an asynchronous FIFO. It keeps the read pointer and brings the write pointer into the read clock domain through a two-stage synchronizer on a Gray-coded bus. From the two pointers it works out how many words are stored. It drives the read address into an external storage array, registers the words it returns, and presents them on a data bus. A separate drive-enable output acts as the tristate control for that bus.

Two timing behaviours are latched while master reset is low. In standard mode a word reaches the bus only when it is requested. In fall-through mode the head word is loaded into the output register without any request, and a request consumes it. Independently, the port can deliver one word per rising edge or two words per clock cycle, one in each half of the cycle. Fall-through timing exists only at single rate.

A registered chip select gates read requests and the bus drive. An asynchronous output enable also removes the drive. The block generates two main status flags whose meaning depends on the mode, plus almost-empty and almost-full flags with parameter thresholds. An echo read-enable and an echo clock accompany the data for the receiver.

Top module: `rdp_read_port`

## Requirements
- R1: In standard mode, qOut changes only at a rising edge where renN was low, the registered chip select was active and a word was stored; at every other edge it holds its value.
- R2: In fall-through mode, a word written into empty storage appears on qOut, and statusE goes to 1, at the third rising edge after the write pointer changes, with renN held high. Each later word needs a rising edge with renN low. A request made when storage is empty drops statusE to 0.
- R3: fwftSel and sdrSel are latched while mrstN is low. sdrSel=0 selects double rate and forces standard mode whatever fwftSel is.
- R4: In standard mode, statusE=1 means no word is available and statusF=1 means 2^ADDR_W words are stored. In fall-through mode, statusE=1 means a valid word is on qOut and statusF=1 means there is room for another word.
- R5: At double rate, each rising edge that serves a read consumes two words. qOut shows the first word while rdClk is high and the second while rdClk is low. A read needs at least two stored words, and statusE=1 while fewer than two are stored.
- R6: rcsN is registered on rdClk. While the registered value is 1, renN is ignored and qDrive=0.
- R7: oeN=1 forces qDrive=0 at once, with no rdClk edge.
- R8: almostEmpty=1 when the stored count is at most AE_OFS. almostFull=1 when the stored count is at least 2^ADDR_W-AF_OFS.
- R9: echoRen=1 in the cycle after each edge that consumed a word for the reader. echoClk is 0 during reset and follows rdClk after reset.
- R10: The read pointer never advances while storage is empty, so a request on empty storage leaves qOut unchanged and echoRen at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rdClk | input | 1 | Read clock |
| mrstN | input | 1 | Master reset, active low, synchronous; mode pins are latched while it is low |
| renN | input | 1 | Read request, active low; held high during reset |
| rcsN | input | 1 | Chip select, active low, registered on rdClk |
| oeN | input | 1 | Output enable, active low, asynchronous |
| fwftSel | input | 1 | 1 selects fall-through timing (latched in reset) |
| sdrSel | input | 1 | 1 selects single rate, 0 selects double rate (latched in reset) |
| wrPtrGray | input | ADDR_W+1 | Write pointer in Gray code, from the write domain |
| memLo | input | DATA_W | Storage word at memAddr |
| memHi | input | DATA_W | Storage word at memAddr+1 |
| memAddr | output | ADDR_W | Storage read address |
| qOut | output | DATA_W | Read data bus |
| qDrive | output | 1 | 1 while qOut should be driven, 0 for high impedance |
| statusE | output | 1 | Empty flag (standard) or output-ready flag (fall-through) |
| statusF | output | 1 | Full flag (standard) or input-ready flag (fall-through) |
| almostEmpty | output | 1 | Stored count at or below AE_OFS |
| almostFull | output | 1 | Stored count at or above 2^ADDR_W-AF_OFS |
| echoRen | output | 1 | Registered strobe marking a consumed word |
| echoClk | output | 1 | Forwarded read clock |

## Verification
On every cycle, the assertions check the properties that hold between adjacent cycles. The output register holds when no load is strobed. The pointer does not move while the registered chip select is off in standard mode. The pointer never advances from an empty count, and it steps by exactly two at double rate. Double rate never coexists with fall-through timing, and an unrequested output-ready flag stays set. Only the bench scenarios can show the data sequence at the bus and the three-edge fall-through latency. The same holds for the mode-dependent flag meanings, the almost thresholds, the half-cycle word order at double rate, and the asynchronous output-enable path.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef struct packed {
    logic load;   // capture storage data into the output register(s)
    logic pair;   // capture both words (double rate)
    logic echo;   // a word was consumed by the reader
  } rdStrobe_t;
endpackage

// File: rtl/rdp_ctrl.sv
module rdp_ctrl
  import rdp_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int AE_OFS = 2,
  parameter int AF_OFS = 2
) (
  input  logic              rdClk,
  input  logic              mrstN,
  input  logic              renN,
  input  logic              rcsN,
  input  logic              fwftSel,
  input  logic              sdrSel,
  input  logic [ADDR_W:0]   wrPtrGray,
  output rdStrobe_t         strb,
  output logic [ADDR_W-1:0] memAddr,
  output logic              csOff,
  output logic              ddrMode,
  output logic              live,
  output logic              statusE,
  output logic              statusF,
  output logic              almostEmpty,
  output logic              almostFull
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] FULL_C = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] AE_C   = PTR_W'(AE_OFS);
  localparam logic [PTR_W-1:0] AF_C   = PTR_W'(DEPTH - AF_OFS);
  localparam logic [PTR_W-1:0] ONE_C  = PTR_W'(1);
  localparam logic [PTR_W-1:0] TWO_C  = PTR_W'(2);

  logic [PTR_W-1:0] wrSync1, wrSync2, wrBin, rdPtr, fill;
  logic fwftMode, outValid, reqRead, take, delivered, haveWord, havePair, isFull;

  // Gray to binary: each bit is the parity of itself and all higher bits
  always_comb begin
    for (int i = 0; i < PTR_W; i++) wrBin[i] = ^(wrSync2 >> i);
  end

  assign fill     = wrBin - rdPtr;
  assign haveWord = (fill != '0);
  assign havePair = (fill >= TWO_C);
  assign isFull   = (fill == FULL_C);
  assign reqRead  = !renN && !csOff;

  always_comb begin
    take      = 1'b0;
    delivered = 1'b0;
    if (fwftMode) begin
      take      = haveWord && (!outValid || reqRead);
      delivered = reqRead && outValid;
    end else if (ddrMode) begin
      take      = reqRead && havePair;
      delivered = take;
    end else begin
      take      = reqRead && haveWord;
      delivered = take;
    end
  end

  assign strb.load = take;
  assign strb.pair = ddrMode;
  assign strb.echo = delivered;

  always_ff @(posedge rdClk) begin
    if (!mrstN) begin
      wrSync1  <= '0;
      wrSync2  <= '0;
      rdPtr    <= '0;
      csOff    <= 1'b1;
      outValid <= 1'b0;
      live     <= 1'b0;
      fwftMode <= fwftSel && sdrSel;
      ddrMode  <= !sdrSel;
    end else begin
      wrSync1 <= wrPtrGray;
      wrSync2 <= wrSync1;
      csOff   <= rcsN;
      live    <= 1'b1;
      if (take) rdPtr <= rdPtr + (ddrMode ? TWO_C : ONE_C);
      if (fwftMode) begin
        if (take)         outValid <= 1'b1;
        else if (reqRead) outValid <= 1'b0;
      end
    end
  end

  assign memAddr     = rdPtr[ADDR_W-1:0];
  assign statusE     = fwftMode ? outValid : (ddrMode ? !havePair : !haveWord);
  assign statusF     = fwftMode ? !isFull : isFull;
  assign almostEmpty = (fill <= AE_C);
  assign almostFull  = (fill >= AF_C);

  p_cs_blocks_r6: assert property (@(posedge rdClk) disable iff (!mrstN)
    (!fwftMode && csOff) |=> $stable(rdPtr));

  p_no_underrun_r10: assert property (@(posedge rdClk) disable iff (!mrstN)
    (rdPtr != $past(rdPtr)) |-> ($past(fill) != '0));

  p_pair_step_r5: assert property (@(posedge rdClk) disable iff (!mrstN)
    (ddrMode && (rdPtr != $past(rdPtr))) |-> (PTR_W'(rdPtr - $past(rdPtr)) == TWO_C));

  p_ddr_std_r3: assert property (@(posedge rdClk) disable iff (!mrstN)
    ddrMode |-> !fwftMode);

  p_ready_hold_r2: assert property (@(posedge rdClk) disable iff (!mrstN)
    (fwftMode && outValid && renN) |=> outValid);
endmodule

// File: rtl/rdp_datapath.sv
module rdp_datapath
  import rdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              rdClk,
  input  logic              mrstN,
  input  rdStrobe_t         strb,
  input  logic              ddrMode,
  input  logic              csOff,
  input  logic              oeN,
  input  logic              live,
  input  logic [DATA_W-1:0] memLo,
  input  logic [DATA_W-1:0] memHi,
  output logic [DATA_W-1:0] qOut,
  output logic              qDrive,
  output logic              echoRen,
  output logic              echoClk
);
  logic [DATA_W-1:0] qLo, qHi;

  always_ff @(posedge rdClk) begin
    if (!mrstN) begin
      qLo     <= '0;
      qHi     <= '0;
      echoRen <= 1'b0;
    end else begin
      echoRen <= strb.echo;
      if (strb.load) begin
        qLo <= memLo;
        if (strb.pair) qHi <= memHi;
      end
    end
  end

  // double rate: first word in the high half, second in the low half
  assign qOut    = (ddrMode && !rdClk) ? qHi : qLo;
  assign qDrive  = !oeN && !csOff;
  assign echoClk = rdClk && live;

  p_hold_r1: assert property (@(posedge rdClk) disable iff (!mrstN)
    !strb.load |=> $stable(qLo));
endmodule

// File: rtl/rdp_read_port.sv
module rdp_read_port
  import rdp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int AE_OFS = 2,
  parameter int AF_OFS = 2
) (
  input  logic              rdClk,
  input  logic              mrstN,
  input  logic              renN,
  input  logic              rcsN,
  input  logic              oeN,
  input  logic              fwftSel,
  input  logic              sdrSel,
  input  logic [ADDR_W:0]   wrPtrGray,
  input  logic [DATA_W-1:0] memLo,
  input  logic [DATA_W-1:0] memHi,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] qOut,
  output logic              qDrive,
  output logic              statusE,
  output logic              statusF,
  output logic              almostEmpty,
  output logic              almostFull,
  output logic              echoRen,
  output logic              echoClk
);
  rdStrobe_t strb;
  logic csOff, ddrMode, live;

  rdp_ctrl #(.ADDR_W(ADDR_W), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) uCtrl (
    .rdClk(rdClk), .mrstN(mrstN), .renN(renN), .rcsN(rcsN),
    .fwftSel(fwftSel), .sdrSel(sdrSel), .wrPtrGray(wrPtrGray),
    .strb(strb), .memAddr(memAddr), .csOff(csOff), .ddrMode(ddrMode),
    .live(live), .statusE(statusE), .statusF(statusF),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  rdp_datapath #(.DATA_W(DATA_W)) uData (
    .rdClk(rdClk), .mrstN(mrstN), .strb(strb), .ddrMode(ddrMode),
    .csOff(csOff), .oeN(oeN), .live(live), .memLo(memLo), .memHi(memHi),
    .qOut(qOut), .qDrive(qDrive), .echoRen(echoRen), .echoClk(echoClk)
  );
endmodule

// File: tb/tb_rdp_read_port.sv
module tb_rdp_read_port;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic mrstN = 1'b0, renN = 1'b1, rcsN = 1'b1, oeN = 1'b1;
  logic fwftSel = 1'b0, sdrSel = 1'b1;
  logic [ADDR_W:0] wrBin = '0;
  logic [ADDR_W:0] wrPtrGray;
  logic [DATA_W-1:0] mem [16];
  logic [DATA_W-1:0] memLo, memHi, qOut;
  logic [ADDR_W-1:0] memAddr;
  logic qDrive, statusE, statusF, almostEmpty, almostFull, echoRen, echoClk;
  int nChecks = 0, nErrors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign wrPtrGray = wrBin ^ (wrBin >> 1);
  assign memLo = mem[memAddr];
  assign memHi = mem[ADDR_W'(memAddr + 1'b1)];

  rdp_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .AE_OFS(2), .AF_OFS(2)) dut (
    .rdClk(clk), .mrstN(mrstN), .renN(renN), .rcsN(rcsN), .oeN(oeN),
    .fwftSel(fwftSel), .sdrSel(sdrSel), .wrPtrGray(wrPtrGray),
    .memLo(memLo), .memHi(memHi), .memAddr(memAddr), .qOut(qOut),
    .qDrive(qDrive), .statusE(statusE), .statusF(statusF),
    .almostEmpty(almostEmpty), .almostFull(almostFull),
    .echoRen(echoRen), .echoClk(echoClk)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset(input logic fw, input logic sdr);
    @(negedge clk);
    mrstN = 1'b0; renN = 1'b1; fwftSel = fw; sdrSel = sdr; wrBin = '0;
    repeat (3) @(negedge clk);
    mrstN = 1'b1;
  endtask

  task automatic push(input logic [DATA_W-1:0] d);
    mem[wrBin[ADDR_W-1:0]] = d;
    wrBin = wrBin + 1'b1;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    mrstN = 1'b0; renN = 1'b1; fwftSel = 1'b0; sdrSel = 1'b1; wrBin = '0;
    repeat (2) @(negedge clk);
    @(posedge clk); #5;
    chk("R9 echoClk low in reset", echoClk, 0);
    @(negedge clk);
    mrstN = 1'b1;
    @(negedge clk);
    chk("R4 empty after reset", statusE, 1);
    chk("R4 not full after reset", statusF, 0);
    chk("R8 almostEmpty after reset", almostEmpty, 1);
    chk("R8 almostFull after reset", almostFull, 0);
    chk("R6 no drive with chip select off", qDrive, 0);
    chk("R9 echoRen idle", echoRen, 0);
    @(posedge clk); #5;
    chk("R9 echoClk follows clock high", echoClk, 1);
    @(negedge clk); #1;
    chk("R9 echoClk follows clock low", echoClk, 0);
  endtask

  task automatic testStandard();
    rcsN = 1'b0; oeN = 1'b0;
    push(8'hA1); push(8'hA2); push(8'hA3); settle();
    chk("R4 not empty", statusE, 0);
    chk("R1 no word without request", qOut, 0);
    chk("R6 drive with chip select on", qDrive, 1);
    renN = 1'b0;
    @(negedge clk);
    chk("R1 first read", qOut, 8'hA1);
    chk("R9 echoRen after read", echoRen, 1);
    @(negedge clk);
    chk("R1 second read", qOut, 8'hA2);
    renN = 1'b1;
    @(negedge clk);
    chk("R1 hold without request", qOut, 8'hA2);
    chk("R9 echoRen clears", echoRen, 0);
    renN = 1'b0;
    @(negedge clk);
    chk("R1 last read", qOut, 8'hA3);
    chk("R4 empty after last read", statusE, 1);
    @(negedge clk);
    chk("R10 read on empty keeps data", qOut, 8'hA3);
    chk("R10 no echo on empty", echoRen, 0);
    renN = 1'b1;
  endtask

  task automatic testChipSelect();
    push(8'hB1); settle();
    rcsN = 1'b1;
    @(negedge clk);
    chk("R6 no drive after deselect", qDrive, 0);
    renN = 1'b0;
    @(negedge clk);
    renN = 1'b1;
    chk("R6 request ignored, word still stored", statusE, 0);
    rcsN = 1'b0;
    @(negedge clk);
    chk("R6 drive restored", qDrive, 1);
    chk("R6 data unchanged by ignored request", qOut, 8'hA3);
    renN = 1'b0;
    @(negedge clk);
    renN = 1'b1;
    chk("R6 stored word read afterwards", qOut, 8'hB1);
  endtask

  task automatic testOutputEnable();
    @(negedge clk); #2;
    oeN = 1'b1; #1;
    chk("R7 async tristate", qDrive, 0);
    oeN = 1'b0; #1;
    chk("R7 async drive", qDrive, 1);
  endtask

  task automatic testLevels();
    @(negedge clk);
    push(8'h01); push(8'h02); settle();
    chk("R8 almostEmpty at threshold", almostEmpty, 1);
    push(8'h03); settle();
    chk("R8 almostEmpty above threshold", almostEmpty, 0);
    for (int i = 4; i <= 13; i++) push(DATA_W'(i));
    settle();
    chk("R8 almostFull below threshold", almostFull, 0);
    push(8'h0E); settle();
    chk("R8 almostFull at threshold", almostFull, 1);
    chk("R4 not full at 14", statusF, 0);
    push(8'h0F); push(8'h10); settle();
    chk("R4 full at depth", statusF, 1);
    renN = 1'b0;
    repeat (16) @(negedge clk);
    renN = 1'b1;
    chk("R1 last drained word", qOut, 8'h10);
    chk("R4 empty after drain", statusE, 1);
  endtask

  task automatic testFallThrough();
    rcsN = 1'b0;
    doReset(1'b1, 1'b1);
    @(negedge clk);
    chk("R4 input ready after reset", statusF, 1);
    chk("R4 output not ready after reset", statusE, 0);
    push(8'hC1);
    @(negedge clk);
    chk("R2 not yet after two edges", statusE, 0);
    chk("R2 bus idle before third edge", qOut, 0);
    @(negedge clk);
    chk("R2 ready on third edge", statusE, 1);
    chk("R2 first word falls through", qOut, 8'hC1);
    push(8'hC2); settle();
    chk("R2 later word waits for request", qOut, 8'hC1);
    renN = 1'b0;
    @(negedge clk);
    chk("R2 request advances", qOut, 8'hC2);
    chk("R2 still ready", statusE, 1);
    chk("R9 echo on consume", echoRen, 1);
    @(negedge clk);
    renN = 1'b1;
    chk("R2 ready drops when drained", statusE, 0);
    chk("R2 data held", qOut, 8'hC2);
  endtask

  task automatic testDouble();
    doReset(1'b1, 1'b0);
    @(negedge clk);
    chk("R3 double rate forces standard empty flag", statusE, 1);
    push(8'hD0); push(8'hD1); push(8'hD2); push(8'hD3); settle();
    chk("R5 pair available", statusE, 0);
    renN = 1'b0;
    @(posedge clk); #5;
    chk("R5 first word in high half", qOut, 8'hD0);
    chk("R9 echoClk high", echoClk, 1);
    @(negedge clk); #5;
    chk("R5 second word in low half", qOut, 8'hD1);
    @(posedge clk); #5;
    chk("R5 third word", qOut, 8'hD2);
    @(negedge clk);
    renN = 1'b1; #5;
    chk("R5 fourth word", qOut, 8'hD3);
    @(negedge clk);
    chk("R5 empty after pairs", statusE, 1);
    push(8'hE0); settle();
    chk("R5 single word is not a pair", statusE, 1);
    renN = 1'b0;
    @(negedge clk);
    renN = 1'b1;
    @(posedge clk); #5;
    chk("R5 no read with one word", qOut, 8'hD2);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    testReset();
    testStandard();
    testChipSelect();
    testOutputEnable();
    testLevels();
    testFallThrough();
    testDouble();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule